// File: doc/BRIEF.md
# Supply-Sense Reset Generator with Chip-Select Watchdog

This block drives a system reset from two sources. A comparator outside the block raises a digital low-supply flag, and reset is held for as long as that flag is set. Reset is then kept asserted for a fixed release interval of continuous good supply. The release interval defaults to 200 ms. A dip of the flag during that interval starts the interval again.

The second source is a watchdog on the active-low chip-select line. When the watchdog is armed, chip select must see a falling edge at least once per selected period. If it stays at either level for longer than that period, a reset pulse is produced. The pulse lasts one release interval, and the watchdog then starts counting again from zero.

All timing comes from a free-running reference clock that is divided into millisecond ticks by a parameter. Both asynchronous inputs pass through two-flop synchronisers before the block uses them. The controller is a four-state machine:

- HOLD: supply is low.
- RELEASE: the supply-release delay is running.
- RUN: reset is released and the watchdog is counting.
- WDOG: a watchdog reset pulse is in progress.

Transitions:

- Any state goes to HOLD when the synchronised supply flag is set.
- HOLD goes to RELEASE when the flag clears.
- RELEASE goes to RUN when the release count completes.
- RUN goes to WDOG when the armed watchdog expires.
- WDOG goes back to RUN when the release count completes.

Top module: `supv_reset_gen`

## Requirements
- R1: Once `supply_low_i` is high at a clock edge, `reset_o` is high no later than 3 clock edges after it and remains high while `supply_low_i` stays high.
- R2: `reset_n_o` is always the inverse of `reset_o`.
- R3: After `supply_low_i` falls, `reset_o` releases `RELEASE_MS*CLK_PER_MS+3` clock edges later (state RELEASE entered, then RUN).
- R4: Any return of `supply_low_i` to high during the release delay restarts the full release interval once it falls again.
- R5: While `rst_n` is low and after it rises, the block starts in HOLD with `reset_o` high.
- R6: With `wdt_en_i` high, `wdt_sel_i` chooses the watchdog period: 2'b00 = `WDT_LONG_MS`, 2'b01 = `WDT_MID_MS`, 2'b10 = `WDT_SHORT_MS`, 2'b11 = watchdog off. Chip select held high past the period causes reset about period*CLK_PER_MS+3 edges after the last falling edge.
- R7: Chip select held low past the selected period also trips the watchdog.
- R8: Only a falling edge of `cs_n_i` restarts the watchdog count. A rising edge has no effect, and falling edges spaced closer than the period keep reset released.
- R9: A watchdog reset pulse lasts `RELEASE_MS*CLK_PER_MS+1` cycles. The watchdog count then restarts from zero, so with chip select quiet the next trip follows after the same number of cycles.
- R10: With `wdt_en_i` low, the watchdog never asserts reset, whatever `cs_n_i` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's logic |
| supply_low_i | input | 1 | Low-supply flag from the comparator, asynchronous |
| cs_n_i | input | 1 | Active-low chip select, asynchronous |
| wdt_en_i | input | 1 | Watchdog enable |
| wdt_sel_i | input | 2 | Watchdog period code |
| reset_o | output | 1 | Reset, active high |
| reset_n_o | output | 1 | Reset, active low |

## Verification
Four properties are checked on every cycle:

- The two reset outputs are always complementary.
- A low-supply sample forces reset within three edges.
- Reset never falls before the raw supply has been good for the full release interval.
- The WDOG state is only entered while the watchdog is enabled and a period is selected.

Only the bench's scenarios can show the rest:

- The exact length of each timeout code.
- That a rising edge of chip select leaves the count alone while a falling edge restarts it.
- That a dip restarts the release delay.
- That a watchdog pulse has the right length and is followed by a fresh count.

// File: rtl/supv_pkg.sv
package supv_pkg;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_RELEASE = 2'd1,
        ST_RUN     = 2'd2,
        ST_WDOG    = 2'd3
    } supv_state_e;

    localparam logic [1:0] SEL_LONG  = 2'b00;
    localparam logic [1:0] SEL_MID   = 2'b01;
    localparam logic [1:0] SEL_SHORT = 2'b10;
    localparam logic [1:0] SEL_OFF   = 2'b11;

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
    parameter int unsigned WIDTH = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/supv_ms_timer.sv
module supv_ms_timer #(
    parameter int unsigned CLK_PER_MS = 50000,
    parameter int unsigned MS_W       = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    output logic [MS_W-1:0] ms_cnt
);
    logic ms_tick;

    generate
        if (CLK_PER_MS <= 1) begin : g_no_div
            assign ms_tick = 1'b1;
        end else begin : g_div
            localparam int unsigned PS_W = $clog2(CLK_PER_MS);
            localparam logic [PS_W-1:0] PS_LAST = PS_W'(CLK_PER_MS - 1);
            logic [PS_W-1:0] ps_cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                ps_cnt <= '0;
                else if (clr)              ps_cnt <= '0;
                else if (ps_cnt == PS_LAST) ps_cnt <= '0;
                else                       ps_cnt <= ps_cnt + 1'b1;
            end
            assign ms_tick = (ps_cnt == PS_LAST);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         ms_cnt <= '0;
        else if (clr)                       ms_cnt <= '0;
        else if (ms_tick && (ms_cnt != '1)) ms_cnt <= ms_cnt + 1'b1;
    end
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
    import supv_pkg::*;
#(
    parameter int unsigned CLK_PER_MS   = 50000,
    parameter int unsigned RELEASE_MS   = 200,
    parameter int unsigned WDT_LONG_MS  = 1400,
    parameter int unsigned WDT_MID_MS   = 600,
    parameter int unsigned WDT_SHORT_MS = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_low_i,
    input  logic       cs_n_i,
    input  logic       wdt_en_i,
    input  logic [1:0] wdt_sel_i,
    output logic       reset_o,
    output logic       reset_n_o
);
    localparam int unsigned MAX_A  = (RELEASE_MS > WDT_LONG_MS) ? RELEASE_MS : WDT_LONG_MS;
    localparam int unsigned MAX_B  = (WDT_MID_MS > WDT_SHORT_MS) ? WDT_MID_MS : WDT_SHORT_MS;
    localparam int unsigned MS_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned MS_W   = $clog2(MS_MAX + 2);

    localparam logic [MS_W-1:0] LIM_REL   = MS_W'(RELEASE_MS);
    localparam logic [MS_W-1:0] LIM_LONG  = MS_W'(WDT_LONG_MS);
    localparam logic [MS_W-1:0] LIM_MID   = MS_W'(WDT_MID_MS);
    localparam logic [MS_W-1:0] LIM_SHORT = MS_W'(WDT_SHORT_MS);

    supv_state_e     state, state_nx;
    logic            sup_low_s, cs_s, cs_prev, cs_fall;
    logic            wdt_armed, timer_clr;
    logic [MS_W-1:0] wdt_limit, ms_cnt;

    // Both asynchronous inputs pass two flops; reset values mean low supply and deselected.
    supv_sync #(.WIDTH(2), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({supply_low_i, cs_n_i}),
        .q     ({sup_low_s, cs_s})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_prev <= 1'b1;
        else        cs_prev <= cs_s;
    end
    assign cs_fall = cs_prev & ~cs_s;

    always_comb begin
        wdt_armed = wdt_en_i;
        wdt_limit = LIM_SHORT;
        unique case (wdt_sel_i)
            SEL_LONG:  wdt_limit = LIM_LONG;
            SEL_MID:   wdt_limit = LIM_MID;
            SEL_SHORT: wdt_limit = LIM_SHORT;
            SEL_OFF:   wdt_armed = 1'b0;
            default:   wdt_armed = 1'b0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= state_nx;
    end

    // Next-state logic; low supply takes priority from every state
    always_comb begin
        state_nx = state;
        if (sup_low_s) begin
            state_nx = ST_HOLD;
        end else begin
            unique case (state)
                ST_HOLD:    state_nx = ST_RELEASE;
                ST_RELEASE: if (ms_cnt == LIM_REL) state_nx = ST_RUN;
                ST_RUN:     if (wdt_armed && !cs_fall && (ms_cnt == wdt_limit))
                                state_nx = ST_WDOG;
                ST_WDOG:    if (ms_cnt == LIM_REL) state_nx = ST_RUN;
                default:    state_nx = ST_HOLD;
            endcase
        end
    end

    // One timer serves both intervals: cleared on every state change,
    // and in RUN on a chip-select fall or while the watchdog is off.
    assign timer_clr = (state_nx != state) ||
                       ((state == ST_RUN) && (cs_fall || !wdt_armed));

    supv_ms_timer #(.CLK_PER_MS(CLK_PER_MS), .MS_W(MS_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (timer_clr),
        .ms_cnt (ms_cnt)
    );

    // Output decode
    always_comb begin
        reset_o   = (state != ST_RUN);
        reset_n_o = (state == ST_RUN);
    end
endmodule

// File: rtl/supv_reset_gen_chk.sv
module supv_reset_gen_chk
    import supv_pkg::*;
#(
    parameter int unsigned CLK_PER_MS = 50000,
    parameter int unsigned RELEASE_MS = 200
) (
    input logic        clk,
    input logic        rst_n,
    input logic        supply_low_i,
    input logic        wdt_en_i,
    input logic [1:0]  wdt_sel_i,
    input logic        reset_o,
    input logic        reset_n_o,
    input supv_state_e state
);
    localparam logic [31:0] NEED = 32'(RELEASE_MS * CLK_PER_MS);
    logic [31:0] good_cnt;

    // Consecutive cycles of good raw supply, saturating at the release length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              good_cnt <= '0;
        else if (supply_low_i)   good_cnt <= '0;
        else if (good_cnt < NEED) good_cnt <= good_cnt + 1'b1;
    end

    a_r2_outputs_complement: assert property (@(posedge clk) disable iff (!rst_n)
        reset_n_o == !reset_o);

    a_r1_low_supply_forces_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(supply_low_i, 3) |-> reset_o);

    a_r3_no_early_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reset_o) |-> (good_cnt >= NEED));

    a_r10_wdog_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_WDOG) |-> ($past(wdt_en_i) && ($past(wdt_sel_i) != SEL_OFF)));
endmodule

bind supv_reset_gen supv_reset_gen_chk #(
    .CLK_PER_MS (CLK_PER_MS),
    .RELEASE_MS (RELEASE_MS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_low_i (supply_low_i),
    .wdt_en_i     (wdt_en_i),
    .wdt_sel_i    (wdt_sel_i),
    .reset_o      (reset_o),
    .reset_n_o    (reset_n_o),
    .state        (state)
);

// File: tb/supv_reset_gen_bench.sv
`timescale 1ns/1ps
module supv_reset_gen_bench;
    localparam int P    = 4;
    localparam int REL  = 200;
    localparam int REL_EDGES = REL * P + 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_low_i = 1'b1;
    logic       cs_n_i = 1'b1;
    logic       wdt_en_i = 1'b0;
    logic [1:0] wdt_sel_i = 2'b10;
    logic       reset_o, reset_n_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    supv_reset_gen #(.CLK_PER_MS(P)) u_supv_reset_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_low_i (supply_low_i),
        .cs_n_i       (cs_n_i),
        .wdt_en_i     (wdt_en_i),
        .wdt_sel_i    (wdt_sel_i),
        .reset_o      (reset_o),
        .reset_n_o    (reset_n_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    // Count edges until reset_o reaches lvl (limit bounds the wait)
    task automatic edges_until(input logic lvl, input int limit, output int cnt);
        cnt = 0;
        while (cnt < limit) begin
            @(posedge clk); #1;
            cnt++;
            if (reset_o == lvl) break;
        end
    endtask

    task automatic settle();
        int c;
        @(negedge clk); wdt_en_i = 1'b0; cs_n_i = 1'b1;
        edges_until(1'b0, 3000, c);
        step(10);
    endtask

    task automatic t_power_up();
        int c;
        step(3);
        check(reset_o == 1'b1, "R5", reset_o, 1);
        check(reset_n_o == 1'b0, "R2", reset_n_o, 0);
        @(negedge clk); rst_n = 1'b1;
        step(20);
        check(reset_o == 1'b1, "R5", reset_o, 1);
        @(negedge clk); supply_low_i = 1'b0;
        edges_until(1'b0, 5000, c);
        check(c >= REL_EDGES - 2 && c <= REL_EDGES + 2, "R3", c, REL_EDGES);
        check(reset_n_o == 1'b1, "R2", reset_n_o, 1);
    endtask

    task automatic t_brownout();
        int c, highs;
        @(negedge clk); supply_low_i = 1'b1;
        edges_until(1'b1, 50, c);
        check(c <= 3, "R1", c, 3);
        highs = 0;
        for (int i = 0; i < 300; i++) begin
            step(1);
            if (reset_o) highs++;
        end
        check(highs == 300, "R1", highs, 300);
        @(negedge clk); supply_low_i = 1'b0;
        edges_until(1'b0, 5000, c);
        check(c >= REL_EDGES - 2 && c <= REL_EDGES + 2, "R3", c, REL_EDGES);
    endtask

    task automatic t_dip();
        int c;
        @(negedge clk); supply_low_i = 1'b1;
        step(5);
        @(negedge clk); supply_low_i = 1'b0;
        step(400);
        @(negedge clk); supply_low_i = 1'b1;
        step(4);
        @(negedge clk); supply_low_i = 1'b0;
        edges_until(1'b0, 5000, c);
        check(c >= REL_EDGES - 2 && c <= REL_EDGES + 2, "R4", c, REL_EDGES);
    endtask

    task automatic t_quiet(input logic en, input logic [1:0] sel, input string req);
        int highs = 0;
        settle();
        @(negedge clk); wdt_sel_i = sel; wdt_en_i = en;
        cs_n_i = 1'b0;
        step(5);
        @(negedge clk); cs_n_i = 1'b1;
        for (int i = 0; i < 2000; i++) begin
            step(1);
            if (reset_o) highs++;
        end
        check(highs == 0, req, highs, 0);
    endtask

    // Fall on cs_n, rise after rise_after cycles (0 = stay low), measure trip
    task automatic t_trip(input logic [1:0] sel, input int ms, input int rise_after,
                          input string req);
        int c, exp;
        settle();
        @(negedge clk); wdt_sel_i = sel; wdt_en_i = 1'b1;
        step(3);
        @(negedge clk); cs_n_i = 1'b0;
        c = 0;
        while (c < 20000) begin
            @(posedge clk); #1;
            c++;
            if (reset_o) break;
            if (rise_after != 0 && c == rise_after) begin
                @(negedge clk); cs_n_i = 1'b1;
            end
        end
        exp = ms * P + 3;
        check(c >= exp - 3 && c <= exp + 3, req, c, exp);
    endtask

    task automatic t_pulse_and_rearm();
        int c, exp;
        t_trip(2'b10, 200, 5, "R6");
        edges_until(1'b0, 5000, c);
        exp = REL * P + 1;
        check(c >= exp - 3 && c <= exp + 3, "R9", c, exp);
        edges_until(1'b1, 5000, c);
        exp = 200 * P + 1;
        check(c >= exp - 3 && c <= exp + 3, "R9", c, exp);
    endtask

    task automatic t_kick();
        int highs = 0;
        settle();
        @(negedge clk); wdt_sel_i = 2'b10; wdt_en_i = 1'b1;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); cs_n_i = 1'b0;
            for (int i = 0; i < 10; i++) begin step(1); if (reset_o) highs++; end
            @(negedge clk); cs_n_i = 1'b1;
            for (int i = 0; i < 590; i++) begin step(1); if (reset_o) highs++; end
        end
        check(highs == 0, "R8", highs, 0);
    endtask

    initial begin
        t_power_up();
        t_brownout();
        t_dip();
        t_quiet(1'b0, 2'b10, "R10");
        t_quiet(1'b1, 2'b11, "R6");
        t_trip(2'b10, 200, 5, "R6");
        t_trip(2'b01, 600, 5, "R6");
        t_trip(2'b00, 1400, 5, "R6");
        t_trip(2'b10, 200, 0, "R7");
        t_trip(2'b10, 200, 400, "R8");
        t_kick();
        t_pulse_and_rearm();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule